// File: doc/BRIEF.md
# Sync Pulse Regenerator for Data-Enable-Only Video

Some video sources deliver pixels with only a data-enable qualifier and no horizontal or vertical sync. This block rebuilds both syncs so that downstream logic can still tell line boundaries from frame boundaries. It measures each run of consecutive pixels with data-enable low. Two programmable thresholds, both in pixels, sit on that run length. When the run reaches the shorter threshold, a line sync is emitted. When the same run reaches the longer threshold, a frame sync is emitted.

Each sync is an active-high pulse of fixed width. The block does not attempt to reproduce the source's original sync positions, widths or porches. If the thresholds are programmed in the wrong order, the block raises a configuration error and stays silent. With the enable low, the block is transparent: the sync inputs appear unchanged on the outputs.

Top module: `de_sync_regen`

## Requirements
- R1: After a synchronous active-low reset, with the enable high, data-enable high and a valid configuration, both sync outputs are 0.
- R2: The run length counts consecutive clock edges at which `de_in` is 0. A single edge with `de_in` = 1 clears it to 0.
- R3: When a run reaches `h_gap` pixels, `hsync_out` goes high in the cycle after the `h_gap`-th low pixel. It stays high for exactly PULSE_W cycles (default 4), whatever `de_in` does meanwhile.
- R4: When a run reaches `v_gap` pixels, `vsync_out` goes high in the cycle after the `v_gap`-th low pixel, for PULSE_W cycles. Within one run, the line sync (at `h_gap`) always fires before the frame sync.
- R5: Each threshold produces at most one pulse per data-enable-low run. A run shorter than a threshold produces no pulse for it. A new run after a data-enable-high pixel can trigger again.
- R6: The run length saturates at 2^CNT_W-1 and does not wrap. A run longer than that produces no further pulses, even when a threshold equals the saturation value.
- R7: `cfg_err` is 1 in the same cycle whenever `h_gap` <= 1 or `h_gap` >= `v_gap`, and 0 otherwise.
- R8: While `cfg_err` is 1 and the enable is high, both sync outputs are 0 at once. A pulse already in progress is terminated and does not resume.
- R9: While `enable` is 0, `hsync_out` equals `hsync_in` and `vsync_out` equals `vsync_in` in the same cycle, and no pulse is armed. After the enable returns, a pulse can only come from a threshold crossing that occurs while the enable is high.
- R10: Pulses are active high. Outside a pulse, with the enable high, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | 1 regenerates syncs, 0 passes the sync inputs through |
| de_in | input | 1 | Data-enable, 1 marks an active pixel |
| hsync_in | input | 1 | Incoming line sync, used only in pass-through |
| vsync_in | input | 1 | Incoming frame sync, used only in pass-through |
| h_gap | input | CNT_W | Line-sync threshold in blank pixels |
| v_gap | input | CNT_W | Frame-sync threshold in blank pixels |
| hsync_out | output | 1 | Regenerated or passed line sync |
| vsync_out | output | 1 | Regenerated or passed frame sync |
| cfg_err | output | 1 | Threshold ordering violated |

## Verification
The bench targets several boundary cases, each of which exposes a specific kind of mistake:

- Blank runs of exactly one pixel less than a threshold: an off-by-one comparison would fire a pulse here.
- The smallest legal pair, `h_gap` = 2 with `v_gap` = 3, where the two pulses overlap: a shared pulse timer would clip one of them.
- A run far longer than the counter range, with `v_gap` set to the saturation value: a wrapping or non-saturating counter would emit extra pulses.
- The configuration is broken mid-pulse, and the enable is toggled mid-run: a design that gated only the start of a pulse would leak a partial pulse, and one that kept its timers armed while bypassed would produce a pulse after re-enabling.

// File: rtl/de_sync_regen_pkg.sv
// Package: shared constants for the sync pulse regenerator.
// Assumes: channel 0 is the line sync and channel 1 is the frame sync.
package de_sync_regen_pkg;
    localparam int unsigned NUM_CH  = 2;
    localparam int unsigned CH_LINE = 0;
    localparam int unsigned CH_FRM  = 1;
endpackage

// File: rtl/de_run_counter.sv
// Module: de_run_counter
// Counts consecutive clock edges with de_in low, saturating at all-ones.
// Assumes: de_in is synchronous to clk; one pixel per clock.
module de_run_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de_in,
    output logic [CNT_W-1:0] run_len,
    output logic             run_sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign run_sat = (run_len == CNT_MAX);

    // Purpose: clear on active pixel, otherwise step up until saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (de_in) begin
            run_len <= '0;
        end else if (!run_sat) begin
            run_len <= run_len + 1'b1;
        end
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        de_in |=> (run_len == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!de_in && !run_sat) |=> (run_len == $past(run_len) + 1'b1));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!de_in && run_sat) |=> run_sat);
endmodule

// File: rtl/gap_threshold_match.sv
// Module: gap_threshold_match
// Raises a one-cycle fire strobe when the blank run is about to reach thresh.
// Assumes: run_len increases by one per low pixel, so equality is met once per run.
module gap_threshold_match #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] run_len,
    input  logic             run_sat,
    input  logic             de_in,
    input  logic             armed,
    input  logic [CNT_W-1:0] thresh,
    output logic             fire
);
    logic [CNT_W-1:0] run_next;

    // Purpose: length the run will have after this pixel, valid only when unsaturated.
    always_comb begin
        run_next = run_len + 1'b1;
    end

    // Purpose: strobe on the pixel that completes the threshold.
    always_comb begin
        fire = armed && !de_in && !run_sat && (run_next == thresh);
    end
endmodule

// File: rtl/sync_pulse_gen.sv
// Module: sync_pulse_gen
// Stretches a fire strobe into a fixed-width active-high pulse.
// Assumes: clr has priority and terminates any pulse in flight.
module sync_pulse_gen #(
    parameter int unsigned PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fire,
    output logic active
);
    localparam int unsigned REM_W = $clog2(PULSE_W + 1);
    localparam logic [REM_W-1:0] REM_LOAD = REM_W'(PULSE_W);

    logic [REM_W-1:0] remain;

    assign active = (remain != '0);

    // Purpose: load width on fire, count down, drop on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (clr) begin
            remain <= '0;
        end else if (fire) begin
            remain <= REM_LOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr) |=> active);

    assert_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !active);

    assert_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= REM_LOAD);
endmodule

// File: rtl/de_sync_regen.sv
// Module: de_sync_regen (top)
// Rebuilds line and frame syncs from data-enable-low run lengths.
// Assumes: h_gap and v_gap are quasi-static; enable low selects pass-through.
module de_sync_regen #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned PULSE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             de_in,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic [CNT_W-1:0] h_gap,
    input  logic [CNT_W-1:0] v_gap,
    output logic             hsync_out,
    output logic             vsync_out,
    output logic             cfg_err
);
    import de_sync_regen_pkg::*;

    logic [CNT_W-1:0]  run_len;
    logic              run_sat;
    logic              armed;
    logic              gen_clr;
    logic [CNT_W-1:0]  thresh [NUM_CH];
    logic [NUM_CH-1:0] fire;
    logic [NUM_CH-1:0] active;

    // Purpose: check threshold ordering (line gap above 1, below frame gap).
    always_comb begin
        cfg_err = !((h_gap > CNT_W'(1)) && (h_gap < v_gap));
    end

    // Purpose: derive arming and clearing of the pulse generators.
    always_comb begin
        armed   = enable && !cfg_err;
        gen_clr = !armed;
    end

    assign thresh[CH_LINE] = h_gap;
    assign thresh[CH_FRM]  = v_gap;

    de_run_counter #(.CNT_W(CNT_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .de_in   (de_in),
        .run_len (run_len),
        .run_sat (run_sat)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        gap_threshold_match #(.CNT_W(CNT_W)) u_match (
            .run_len (run_len),
            .run_sat (run_sat),
            .de_in   (de_in),
            .armed   (armed),
            .thresh  (thresh[ch]),
            .fire    (fire[ch])
        );
        sync_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (gen_clr),
            .fire   (fire[ch]),
            .active (active[ch])
        );
    end

    // Purpose: select regenerated pulses or the raw syncs.
    always_comb begin
        if (enable) begin
            hsync_out = active[CH_LINE] && !cfg_err;
            vsync_out = active[CH_FRM] && !cfg_err;
        end else begin
            hsync_out = hsync_in;
            vsync_out = vsync_in;
        end
    end

    assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire[CH_LINE] && fire[CH_FRM]));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cfg_err) |-> (!hsync_out && !vsync_out));

    assert_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (active == '0));

    assert_one_per_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[CH_LINE] && !de_in) |=> !fire[CH_LINE]);
endmodule

// File: tb/de_sync_regen_bench.sv
// Bench: behavioural reference model compared against the outputs every cycle.
module de_sync_regen_bench;
    localparam int CNT_W   = 8;
    localparam int PULSE_W = 4;
    localparam int RUN_MAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b1;
    logic             de_in = 1'b1;
    logic             hsync_in = 1'b0;
    logic             vsync_in = 1'b0;
    logic [CNT_W-1:0] h_gap = 8'd5;
    logic [CNT_W-1:0] v_gap = 8'd20;
    logic             hsync_out, vsync_out, cfg_err;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // reference state
    int run = 0;
    int h_rem = 0;
    int v_rem = 0;

    always #2.5 clk = ~clk;

    de_sync_regen #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_de_sync_regen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .de_in(de_in),
        .hsync_in(hsync_in), .vsync_in(vsync_in), .h_gap(h_gap), .v_gap(v_gap),
        .hsync_out(hsync_out), .vsync_out(vsync_out), .cfg_err(cfg_err)
    );

    function automatic bit model_err();
        return !((int'(h_gap) > 1) && (int'(h_gap) < int'(v_gap)));
    endfunction

    // reference model update at the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            run = 0; h_rem = 0; v_rem = 0;
        end else begin
            bit ok, fh, fv;
            ok = enable && !model_err();
            fh = ok && !de_in && run < RUN_MAX && (run + 1 == int'(h_gap));
            fv = ok && !de_in && run < RUN_MAX && (run + 1 == int'(v_gap));
            if (de_in) run = 0;
            else if (run < RUN_MAX) run = run + 1;
            if (!ok) h_rem = 0; else if (fh) h_rem = PULSE_W; else if (h_rem > 0) h_rem = h_rem - 1;
            if (!ok) v_rem = 0; else if (fv) v_rem = PULSE_W; else if (v_rem > 0) v_rem = v_rem - 1;
        end
    end

    task automatic check_bit(string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic eh, ev;
        eh = enable ? (h_rem > 0 && !model_err()) : hsync_in;
        ev = enable ? (v_rem > 0 && !model_err()) : vsync_in;
        check_bit("hsync_out", hsync_out, eh);
        check_bit("vsync_out", vsync_out, ev);
        check_bit("cfg_err R7", cfg_err, model_err());
    endtask

    // one pixel: drive at falling edge, compare after settling
    task automatic pix(logic de, logic hs = 1'b0, logic vs = 1'b0);
        @(negedge clk);
        de_in = de; hsync_in = hs; vsync_in = vs;
        #1 compare();
    endtask

    task automatic run_of(logic de, int n);
        for (int i = 0; i < n; i++) pix(de);
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        pix(1'b1);
        check_bit("reset hsync R1", hsync_out, 1'b0);
        check_bit("reset vsync R1", vsync_out, 1'b0);

        tag = "R3";   // line gaps above threshold
        for (int l = 0; l < 3; l++) begin run_of(1'b1, 10); run_of(1'b0, 8); end
        tag = "R5";   // one short of threshold: no pulse
        run_of(1'b1, 6); run_of(1'b0, 4); run_of(1'b1, 10);
        tag = "R4";   // frame gap
        run_of(1'b0, 30); run_of(1'b1, 8);
        tag = "R3";   // de returns during pulse, pulse keeps width
        run_of(1'b0, 5); run_of(1'b1, 8);
        tag = "R2";   // broken run restarts count
        run_of(1'b0, 3); pix(1'b1); run_of(1'b0, 3); run_of(1'b1, 6);

        tag = "R10";  // smallest legal pair, overlapping pulses
        h_gap = 8'd2; v_gap = 8'd3;
        run_of(1'b1, 3); run_of(1'b0, 10); run_of(1'b1, 4);

        tag = "R6";   // saturation with v at the limit
        h_gap = 8'd5; v_gap = 8'd255;
        run_of(1'b1, 3); run_of(1'b0, 600); run_of(1'b1, 4);
        run_of(1'b0, 260); run_of(1'b1, 4);

        tag = "R7";   // ordering violations
        h_gap = 8'd1; v_gap = 8'd20; run_of(1'b0, 25); run_of(1'b1, 3);
        h_gap = 8'd20; v_gap = 8'd20; run_of(1'b0, 25); run_of(1'b1, 3);
        h_gap = 8'd30; v_gap = 8'd20; run_of(1'b0, 35); run_of(1'b1, 3);
        h_gap = 8'd0; run_of(1'b0, 5); run_of(1'b1, 3);

        tag = "R8";   // error mid-pulse
        h_gap = 8'd5; v_gap = 8'd20;
        run_of(1'b1, 3); run_of(1'b0, 6);
        @(negedge clk); h_gap = 8'd25; #1 compare();
        run_of(1'b0, 3);
        h_gap = 8'd5; run_of(1'b0, 20); run_of(1'b1, 4);

        tag = "R9";   // pass-through and re-enable mid-run
        enable = 1'b0;
        for (int i = 0; i < 12; i++) pix(i[0], i[1], i[2]);
        run_of(1'b0, 4);
        enable = 1'b1;
        run_of(1'b0, 25); run_of(1'b1, 4);
        run_of(1'b0, 3);
        enable = 1'b0; run_of(1'b0, 4);
        enable = 1'b1; run_of(1'b0, 20); run_of(1'b1, 4);
        tag = "R4";
        run_of(1'b0, 22); run_of(1'b1, 6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule